// File: doc/BRIEF.md
# Instruction Length Decoder

This block looks at a window of up to fifteen instruction bytes that begins at the current fetch point. It returns the byte length of the first instruction in that window. The length is built up field by field. A run of leading prefix bytes comes first. One or two opcode bytes follow, and the opcode tells whether an addressing byte and an immediate come next. The addressing byte in turn tells whether a scale-index byte and a displacement are present. Each field therefore decides whether the next field exists and how wide it is.

A fetch unit places the bytes at the current instruction pointer into the window and states how many of them are valid. It also states whether the default operand size is 16 or 32 bits. One cycle later the block reports one of four outcomes:
- a length;
- a fault, when the instruction would run past fifteen bytes;
- a request for more bytes, when the window is too short to decide;
- a flag, when the opcode is outside the supported subset.

The fetch unit then shifts the window by the reported length, or refills it.

Top module: `ild_len_decode`

## Requirements
- R1: Each byte in the leading run of prefix bytes (0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2, 0xF3) adds one to the length, and the run may have any length. A prefix value found after the opcode is an ordinary byte.
- R2: A first opcode byte of 0x0F makes the opcode two bytes long. The supported second bytes are: 0x80–0x8F (full immediate), 0xAF, 0xB6 and 0xB7 (addressing byte), 0xBA (addressing byte plus one immediate byte), and 0x05 and 0xA2 (no operands).
- R3: The supported one-byte opcodes fall into these groups:
  - addressing byte only: 0x00–0x03, 0x88–0x8B and 0x8D;
  - addressing byte plus one immediate byte: 0x80, 0x83 and 0xC6;
  - addressing byte plus a full immediate: 0x81 and 0xC7;
  - one immediate byte only: 0x04, 0x6A, 0x70–0x7F, 0xB0–0xB7 and 0xEB;
  - a full immediate only: 0x05, 0x68, 0xB8–0xBF, 0xE8 and 0xE9;
  - a fixed two-byte immediate: 0xC2;
  - no operands: 0x50–0x5F, 0x90 and 0xC3.
- R4: A scale-index byte follows the addressing byte exactly when addressing bits [2:0] are 100 and bits [7:6] are not 11.
- R5: The displacement size comes from the addressing byte:
  - bits [7:6] = 11 gives none;
  - bits [7:6] = 01 gives 1 byte;
  - bits [7:6] = 10 gives 4 bytes;
  - bits [7:6] = 00 with bits [2:0] = 101 gives 4 bytes;
  - any other case with bits [7:6] = 00 gives none.
- R6: When a scale-index byte is present, bits [7:6] of the addressing byte are 00, and bits [2:0] of the scale-index byte are 101, a 4-byte displacement is added.
- R7: A full immediate is 4 bytes when the 16-bit mode input and the presence of a 0x66 prefix are equal. It is 2 bytes when they differ. Byte immediates and the fixed two-byte immediate do not change size.
- R8: When all 15 bytes are valid and the instruction would be longer than 15 bytes, the length fault is raised and the length reads 0.
- R9: When the valid count is below the length computed so far (capped at 15), need-more is raised, the length reads 0 and no fault is raised.
- R10: An opcode outside the supported subset raises the unsupported flag. The length then covers only the prefixes and the opcode bytes.
- R11: All outputs are registered, so they reflect the inputs of the previous clock edge. Reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| win_i | input | 120 | Byte window; byte k is at bits [8k+7:8k], and byte 0 is the first byte of the instruction |
| vcnt_i | input | 4 | Number of valid bytes at the start of the window (0 to 15) |
| opsz16_i | input | 1 | Default operand size: 1 for 16-bit, 0 for 32-bit |
| len_o | output | 4 | Instruction length, or 0 when a fault or need-more is reported |
| len_fault_o | output | 1 | The instruction exceeds the 15-byte limit |
| need_more_o | output | 1 | More valid bytes are needed to decide the length |
| unsup_o | output | 1 | The opcode is outside the supported subset |

## Verification
The assertions assume that the inputs are held for a whole clock period. They also assume that the valid count tells the truth: bytes at or beyond the count may hold anything, and the decoder must never report a length that reaches into them. The stimulus changes inputs only on the falling edge and keeps the valid count within 0 to 15. It mixes directed windows with random windows drawn from a pool of prefix, escape, opcode and addressing values. This keeps long prefix runs, scale-index forms and short valid counts frequent.

// File: rtl/ild_pkg.sv
package ild_pkg;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_BYTE = 2'd1,
    IMM_WORD = 2'd2,
    IMM_FULL = 2'd3
  } imm_kind_e;

  typedef struct packed {
    logic      known;
    logic      has_modrm;
    imm_kind_e imm;
  } op_attr_t;

  function automatic logic is_prefix(input logic [7:0] b);
    case (b)
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: is_prefix = 1'b1;
      default:                                   is_prefix = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 15,
  localparam int CW = $clog2(WIN_BYTES + 1)
) (
  input  logic [8*WIN_BYTES-1:0] win_i,
  output logic [CW-1:0]          pfx_cnt_o,
  output logic                   osz_ovr_o
);

  logic [WIN_BYTES-1:0] is_pfx;
  logic [WIN_BYTES-1:0] run;
  logic [WIN_BYTES-1:0] run_osz;

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte
    assign is_pfx[k]  = is_prefix(win_i[8*k +: 8]);
    if (k == 0) begin : g_first
      assign run[k] = is_pfx[k];
    end else begin : g_rest
      assign run[k] = run[k-1] & is_pfx[k];
    end
    assign run_osz[k] = run[k] & (win_i[8*k +: 8] == 8'h66);
  end

  // run is a thermometer code, so its population is the leading run length
  assign pfx_cnt_o = CW'($countones(run));
  assign osz_ovr_o = |run_osz;

endmodule

// File: rtl/ild_opcode_class.sv
module ild_opcode_class
  import ild_pkg::*;
(
  input  logic [7:0] op0_i,
  input  logic [7:0] op1_i,
  output logic       two_byte_o,
  output op_attr_t   attr_o
);

  always_comb begin
    two_byte_o = (op0_i == 8'h0F);
    attr_o     = '{known: 1'b0, has_modrm: 1'b0, imm: IMM_NONE};
    if (two_byte_o) begin
      casez (op1_i)
        8'b1000_????:        attr_o = '{1'b1, 1'b0, IMM_FULL};
        8'hAF, 8'hB6, 8'hB7: attr_o = '{1'b1, 1'b1, IMM_NONE};
        8'hBA:               attr_o = '{1'b1, 1'b1, IMM_BYTE};
        8'h05, 8'hA2:        attr_o = '{1'b1, 1'b0, IMM_NONE};
        default:             attr_o = '{1'b0, 1'b0, IMM_NONE};
      endcase
    end else begin
      casez (op0_i)
        8'b0000_00??, 8'b1000_10??, 8'h8D:
                             attr_o = '{1'b1, 1'b1, IMM_NONE};
        8'h80, 8'h83, 8'hC6: attr_o = '{1'b1, 1'b1, IMM_BYTE};
        8'h81, 8'hC7:        attr_o = '{1'b1, 1'b1, IMM_FULL};
        8'h04, 8'h6A, 8'hEB, 8'b0111_????, 8'b1011_0???:
                             attr_o = '{1'b1, 1'b0, IMM_BYTE};
        8'h05, 8'h68, 8'hE8, 8'hE9, 8'b1011_1???:
                             attr_o = '{1'b1, 1'b0, IMM_FULL};
        8'hC2:               attr_o = '{1'b1, 1'b0, IMM_WORD};
        8'b0101_????, 8'h90, 8'hC3:
                             attr_o = '{1'b1, 1'b0, IMM_NONE};
        default:             attr_o = '{1'b0, 1'b0, IMM_NONE};
      endcase
    end
  end

endmodule

// File: rtl/ild_modrm_decode.sv
module ild_modrm_decode (
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  output logic       sib_present_o,
  output logic [2:0] disp_len_o
);

  logic [1:0] md;
  logic [2:0] rm;
  logic [2:0] base;

  assign md   = modrm_i[7:6];
  assign rm   = modrm_i[2:0];
  assign base = sib_i[2:0];

  always_comb begin
    sib_present_o = (md != 2'b11) && (rm == 3'b100);
    unique case (md)
      2'b01:   disp_len_o = 3'd1;
      2'b10:   disp_len_o = 3'd4;
      2'b00:   disp_len_o = ((rm == 3'b101) ||
                             (sib_present_o && (base == 3'b101))) ? 3'd4 : 3'd0;
      default: disp_len_o = 3'd0;
    endcase
  end

endmodule

// File: rtl/ild_len_decode.sv
module ild_len_decode
  import ild_pkg::*;
#(
  parameter int WIN_BYTES = 15,
  parameter int MAX_LEN   = 15,
  localparam int CW = $clog2(WIN_BYTES + 1),
  localparam int OW = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*WIN_BYTES-1:0] win_i,
  input  logic [CW-1:0]          vcnt_i,
  input  logic                   opsz16_i,
  output logic [OW-1:0]          len_o,
  output logic                   len_fault_o,
  output logic                   need_more_o,
  output logic                   unsup_o
);

  // widest sum: prefixes + 2 opcode + modrm + sib + 4 disp + 4 imm
  localparam int LW = $clog2(WIN_BYTES + 13);

  function automatic logic [7:0] pick(input logic [8*WIN_BYTES-1:0] w,
                                      input logic [LW-1:0] idx);
    logic [8*WIN_BYTES-1:0] sh;
    sh   = w >> {idx, 3'b000};
    pick = sh[7:0];
  endfunction

  logic [CW-1:0] pfx_cnt;
  logic          osz_ovr;
  logic [LW-1:0] p_ext;
  logic [7:0]    op0, op1;
  logic          two_byte;
  op_attr_t      attr;
  logic [LW-1:0] pos_m;
  logic [7:0]    modrm, sib;
  logic          sib_present;
  logic [2:0]    disp_raw;
  logic [LW-1:0] mlen, dlen, ilen, total, capped;

  logic [OW-1:0] len_d;
  logic          fault_d, need_d, unsup_d;

  ild_prefix_scan #(.WIN_BYTES(WIN_BYTES)) u_pfx (
    .win_i     (win_i),
    .pfx_cnt_o (pfx_cnt),
    .osz_ovr_o (osz_ovr)
  );

  assign p_ext = LW'(pfx_cnt);
  assign op0   = pick(win_i, p_ext);
  assign op1   = pick(win_i, p_ext + LW'(1));

  ild_opcode_class u_opc (
    .op0_i      (op0),
    .op1_i      (op1),
    .two_byte_o (two_byte),
    .attr_o     (attr)
  );

  assign pos_m = p_ext + (two_byte ? LW'(2) : LW'(1));
  assign modrm = pick(win_i, pos_m);
  assign sib   = pick(win_i, pos_m + LW'(1));

  ild_modrm_decode u_mrm (
    .modrm_i       (modrm),
    .sib_i         (sib),
    .sib_present_o (sib_present),
    .disp_len_o    (disp_raw)
  );

  // next-state: field chain and outcome selection
  always_comb begin
    mlen = attr.has_modrm ? (sib_present ? LW'(2) : LW'(1)) : LW'(0);
    dlen = attr.has_modrm ? LW'(disp_raw) : LW'(0);
    unique case (attr.imm)
      IMM_BYTE: ilen = LW'(1);
      IMM_WORD: ilen = LW'(2);
      IMM_FULL: ilen = (opsz16_i ^ osz_ovr) ? LW'(2) : LW'(4);
      default:  ilen = LW'(0);
    endcase
    total  = pos_m + mlen + dlen + ilen;
    capped = (total > LW'(MAX_LEN)) ? LW'(MAX_LEN) : total;
    need_d  = capped > LW'(vcnt_i);
    fault_d = !need_d && (total > LW'(MAX_LEN));
    unsup_d = !need_d && !fault_d && !attr.known;
    len_d   = (need_d || fault_d) ? '0 : OW'(total);
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_o       <= '0;
      len_fault_o <= 1'b0;
      need_more_o <= 1'b0;
      unsup_o     <= 1'b0;
    end else begin
      len_o       <= len_d;
      len_fault_o <= fault_d;
      need_more_o <= need_d;
      unsup_o     <= unsup_d;
    end
  end

endmodule

// File: rtl/ild_len_decode_chk.sv
module ild_len_decode_chk #(
  parameter int WIN_BYTES = 15,
  parameter int MAX_LEN   = 15,
  localparam int CW = $clog2(WIN_BYTES + 1),
  localparam int OW = $clog2(MAX_LEN + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [8*WIN_BYTES-1:0] win_i,
  input logic [CW-1:0]          vcnt_i,
  input logic                   opsz16_i,
  input logic [OW-1:0]          len_o,
  input logic                   len_fault_o,
  input logic                   need_more_o,
  input logic                   unsup_o
);

  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({len_fault_o, need_more_o, unsup_o}));

  assert_len_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (len_fault_o || need_more_o) |-> (len_o == '0));

  assert_len_in_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(len_o) <= 32'($past(vcnt_i))));

  assert_empty_needs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt_i == '0) |=> need_more_o);

  assert_fault_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!len_fault_o || (32'($past(vcnt_i)) >= MAX_LEN)));

  assert_nop_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i[7:0] == 8'h90 && vcnt_i != '0) |=> (len_o == OW'(1) && !unsup_o));

  assert_prefix_adds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i[7:0] == 8'hF3 && win_i[15:8] == 8'h90 && 32'(vcnt_i) >= 2)
      |=> (len_o == OW'(2)));

endmodule

bind ild_len_decode ild_len_decode_chk #(
  .WIN_BYTES(WIN_BYTES),
  .MAX_LEN  (MAX_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_i       (win_i),
  .vcnt_i      (vcnt_i),
  .opsz16_i    (opsz16_i),
  .len_o       (len_o),
  .len_fault_o (len_fault_o),
  .need_more_o (need_more_o),
  .unsup_o     (unsup_o)
);

// File: tb/ild_len_decode_tb.sv
`timescale 1ns/1ps
module ild_len_decode_tb;

  typedef struct {
    logic [3:0] len;
    logic       fault;
    logic       need;
    logic       unsup;
    string      tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [119:0] win;
  logic [3:0]   vcnt;
  logic         m16;
  logic [3:0]   len_o;
  logic         len_fault_o, need_more_o, unsup_o;

  logic [7:0] bb [15];
  exp_t       q [$];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #2.5 clk = ~clk;

  ild_len_decode u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_i       (win),
    .vcnt_i      (vcnt),
    .opsz16_i    (m16),
    .len_o       (len_o),
    .len_fault_o (len_fault_o),
    .need_more_o (need_more_o),
    .unsup_o     (unsup_o)
  );

  function automatic logic [7:0] rb(input int i);
    return (i < 15) ? bb[i] : 8'h00;
  endfunction

  function automatic logic isp(input logic [7:0] b);
    return b inside {8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
                     8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
  endfunction

  // requirement-level model: ik 0 none, 1 byte, 2 fixed word, 3 full
  function automatic exp_t model(input logic [3:0] v, input logic m);
    exp_t e;
    int p = 0, n, ik = 0, imm = 0;
    logic ovr = 0, known = 0, mrm = 0;
    logic [7:0] op, md;
    while (p < 15 && isp(rb(p))) begin
      if (rb(p) == 8'h66) ovr = 1;
      p++;
    end
    op = rb(p); n = p + 1;
    if (op == 8'h0F) begin
      op = rb(n); n++; known = 1;
      if (op inside {[8'h80:8'h8F]}) ik = 3;
      else if (op inside {8'hAF, 8'hB6, 8'hB7}) mrm = 1;
      else if (op == 8'hBA) begin mrm = 1; ik = 1; end
      else if (!(op inside {8'h05, 8'hA2})) known = 0;
    end else begin
      known = 1;
      if (op inside {[8'h00:8'h03], [8'h88:8'h8B], 8'h8D}) mrm = 1;
      else if (op inside {8'h80, 8'h83, 8'hC6}) begin mrm = 1; ik = 1; end
      else if (op inside {8'h81, 8'hC7}) begin mrm = 1; ik = 3; end
      else if (op inside {8'h04, 8'h6A, 8'hEB, [8'h70:8'h7F], [8'hB0:8'hB7]}) ik = 1;
      else if (op inside {8'h05, 8'h68, 8'hE8, 8'hE9, [8'hB8:8'hBF]}) ik = 3;
      else if (op == 8'hC2) ik = 2;
      else if (!(op inside {[8'h50:8'h5F], 8'h90, 8'hC3})) known = 0;
    end
    if (mrm) begin
      md = rb(n); n++;
      if (md[7:6] != 2'b11 && md[2:0] == 3'b100) begin
        if (md[7:6] == 2'b00 && rb(n) % 8 == 5) n += 4;
        n++;
      end
      if (md[7:6] == 2'b01) n += 1;
      else if (md[7:6] == 2'b10) n += 4;
      else if (md[7:6] == 2'b00 && md[2:0] == 3'b101) n += 4;
    end
    if (ik == 1) imm = 1;
    else if (ik == 2) imm = 2;
    else if (ik == 3) imm = (m ^ ovr) ? 2 : 4;
    n += imm;
    e = '{4'd0, 1'b0, 1'b0, 1'b0, "rand R1 R4 R5 R6 R7"};
    if (((n > 15) ? 15 : n) > int'(v)) e.need = 1;
    else if (n > 15) e.fault = 1;
    else begin
      e.len   = 4'(n);
      e.unsup = !known;
    end
    return e;
  endfunction

  task automatic clr();
    for (int i = 0; i < 15; i++) bb[i] = 8'h00;
  endtask

  task automatic fill(input int from, input int cnt, input logic [7:0] b);
    for (int i = from; i < from + cnt && i < 15; i++) bb[i] = b;
  endtask

  task automatic drive(input string tag, input logic [3:0] v, input logic m,
                       input logic [3:0] el, input logic ef, input logic en,
                       input logic eu);
    @(negedge clk);
    for (int i = 0; i < 15; i++) win[8*i +: 8] = bb[i];
    vcnt = v;
    m16  = m;
    q.push_back('{el, ef, en, eu, tag});
  endtask

  // monitor: one registered result per driven item
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      n_chk++;
      if (len_o !== e.len || len_fault_o !== e.fault ||
          need_more_o !== e.need || unsup_o !== e.unsup) begin
        n_bad++;
        $display("FAIL %s: got len=%0d fault=%0b need=%0b unsup=%0b exp len=%0d fault=%0b need=%0b unsup=%0b",
                 e.tag, len_o, len_fault_o, need_more_o, unsup_o,
                 e.len, e.fault, e.need, e.unsup);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clr();
    fill(0, 1, 8'h90);
    win  = '0;
    win[7:0] = 8'h90;
    vcnt = 4'd15;
    m16  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (len_o !== 4'd0 || len_fault_o || need_more_o || unsup_o) begin
      n_bad++;
      $display("FAIL R11 reset: got len=%0d flags=%0b%0b%0b exp 0 000",
               len_o, len_fault_o, need_more_o, unsup_o);
    end
    rst_n = 1'b1;

    clr(); bb[0] = 8'h90;
    drive("R11 R3 nop", 15, 0, 1, 0, 0, 0);
    clr(); bb[0] = 8'h66; bb[1] = 8'hF3; bb[2] = 8'h90;
    drive("R1 two prefixes", 15, 0, 3, 0, 0, 0);
    clr(); bb[0] = 8'h90; bb[1] = 8'h66;
    drive("R1 trailing prefix value", 15, 0, 1, 0, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'hC0;
    drive("R5 mod11 no disp", 15, 0, 2, 0, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h44; bb[2] = 8'h24; bb[3] = 8'h08;
    drive("R4 sib disp8", 15, 0, 4, 0, 0, 0);
    drive("R9 one short", 3, 0, 0, 0, 1, 0);
    drive("R9 exact fit", 4, 0, 4, 0, 0, 0);
    drive("R9 empty", 0, 0, 0, 0, 1, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h05;
    drive("R5 mod00 rm101 disp32", 15, 0, 6, 0, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h04; bb[2] = 8'h25;
    drive("R6 sib base101", 15, 0, 7, 0, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h04; bb[2] = 8'h24;
    drive("R6 sib base100 no disp", 15, 0, 3, 0, 0, 0);
    clr(); bb[0] = 8'h8B; bb[1] = 8'h84; bb[2] = 8'h24;
    drive("R5 mod10 sib disp32", 15, 0, 7, 0, 0, 0);
    clr(); bb[0] = 8'h81; bb[1] = 8'hC0;
    drive("R7 full imm 32", 15, 0, 6, 0, 0, 0);
    drive("R7 mode16 imm", 15, 1, 4, 0, 0, 0);
    clr(); bb[0] = 8'h66; bb[1] = 8'h81; bb[2] = 8'hC0;
    drive("R7 prefix imm16", 15, 0, 5, 0, 0, 0);
    drive("R7 mode16 plus prefix", 15, 1, 7, 0, 0, 0);
    clr(); bb[0] = 8'h66; bb[1] = 8'h83; bb[2] = 8'hC0;
    drive("R7 byte imm unaffected", 15, 0, 4, 0, 0, 0);
    clr(); bb[0] = 8'h66; bb[1] = 8'hC2;
    drive("R7 word imm unaffected", 15, 0, 4, 0, 0, 0);
    clr(); bb[0] = 8'hB8;
    drive("R3 mov imm full", 15, 0, 5, 0, 0, 0);
    clr(); bb[0] = 8'hB3;
    drive("R3 mov imm8", 15, 0, 2, 0, 0, 0);
    clr(); bb[0] = 8'hE8;
    drive("R3 call rel", 15, 0, 5, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'h84;
    drive("R2 escape jcc", 15, 0, 6, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'hAF; bb[2] = 8'hC1;
    drive("R2 escape modrm", 15, 0, 3, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'h05;
    drive("R2 escape bare", 15, 0, 2, 0, 0, 0);
    clr(); bb[0] = 8'h0F; bb[1] = 8'hFF;
    drive("R10 unknown escape", 15, 0, 2, 0, 0, 1);
    clr(); bb[0] = 8'hF0; bb[1] = 8'hD8;
    drive("R10 unknown one-byte", 15, 0, 2, 0, 0, 1);
    clr(); fill(0, 9, 8'hF3); bb[9] = 8'h81; bb[10] = 8'hC0;
    drive("R8 exactly 15", 15, 0, 15, 0, 0, 0);
    clr(); fill(0, 10, 8'hF3); bb[10] = 8'h81; bb[11] = 8'hC0;
    drive("R8 sixteen", 15, 0, 0, 1, 0, 0);
    drive("R9 over limit short window", 14, 0, 0, 0, 1, 0);
    clr(); fill(0, 15, 8'h2E);
    drive("R8 all prefixes", 15, 0, 0, 1, 0, 0);
    clr(); fill(0, 14, 8'h3E); bb[14] = 8'h90;
    drive("R1 fourteen prefixes", 15, 0, 15, 0, 0, 0);

    for (int t = 0; t < 400; t++) begin
      exp_t e;
      logic [3:0] v;
      logic m;
      for (int i = 0; i < 15; i++) begin
        case ($urandom_range(0, 15))
          0:  bb[i] = 8'h66;
          1:  bb[i] = 8'hF3;
          2:  bb[i] = 8'h0F;
          3:  bb[i] = 8'h8B;
          4:  bb[i] = 8'h81;
          5:  bb[i] = 8'hC7;
          6:  bb[i] = 8'h44;
          7:  bb[i] = 8'h04;
          8:  bb[i] = 8'h84;
          9:  bb[i] = 8'h25;
          10: bb[i] = 8'h05;
          11: bb[i] = 8'hC2;
          12: bb[i] = 8'h26;
          default: bb[i] = 8'($urandom);
        endcase
      end
      v = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 14)) : 4'd15;
      m = 1'($urandom);
      e = model(v, m);
      drive(e.tag, v, m, e.len, e.fault, e.need, e.unsup);
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule